// File: doc/BRIEF.md
# Power-on and lock reset sequencer

This block produces the system reset for an FPGA design that has no reliable reset pin of its own. Its registers take their starting values from initializers in the code. A power-up countdown therefore begins as soon as configuration finishes and holds the system in reset until the countdown reaches zero. No one has to press a button.

Two inputs can also hold or restart reset. The first is an external push-button, which is active low. The second is the lock indicator of the clock generator. Each input passes through its own synchronizer. While either one is asserting, reset is held. When the last of them releases, reset stays high for a further, programmable number of cycles. If a new cause appears during that window, the window starts again at its full length. Reset is always released on a system clock edge. An active-high output and an active-low output are registered, and both change on the same edge. A sticky status output shows that at least one release has occurred since power-up.

Top module: `rstseq_top`

## Requirements
- R1: With the button released (high) and lock high from time zero, `sys_rst` is 1 from time zero and first falls on the rising edge numbered `POR_CYCLES`+1, counting the first edge as 1. The block has no reset input.
- R2: If lock goes low just before a rising edge, `sys_rst` is 1 no later than the third rising edge after that change. It stays 1 for as long as lock is low.
- R3: When lock returns high with no other cause present, `sys_rst` falls on rising edge number `STRETCH_CYCLES`+3 after the change. The first edge after the change counts as 1.
- R4: The button input is active low. A low level asserts `sys_rst` with the same latency as R2. Its release is stretched exactly as in R3.
- R5: A new cause that occurs while the post-release stretch is running reloads the stretch to its full length. Release then follows R3, timed from the end of the latest cause.
- R6: `sys_rst_n` is always the complement of `sys_rst`, and the two change on the same clock edge.
- R7: `seq_done` is 0 until the first fall of `sys_rst` and rises on that same edge. It then stays 1 through every later reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| btn_n_async | input | 1 | External reset button, active low, asynchronous |
| pll_lock_async | input | 1 | Clock generator lock indicator, asynchronous |
| sys_rst | output | 1 | Registered system reset, active high |
| sys_rst_n | output | 1 | Registered system reset, active low |
| seq_done | output | 1 | Sticky: a reset release has occurred since power-up |

## Verification
The bench builds the block with `POR_CYCLES`=20, `STRETCH_CYCLES`=5 and the default two synchronizer stages. With these values the power-up release and several stretched releases all fit in a few hundred cycles. The short stretch lets the bench place a second cause inside a running stretch window and check that the window reloads. Each release edge is predicted exactly from the synchronizer depth and the stretch length, so an error of one cycle in either shows up as a mismatch.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   // width of a down-counter that must hold the value n
   function automatic int cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int STAGES = 2,
   parameter bit IDLE   = 1'b0
) (
   input  logic clk,
   input  logic d_async,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain = {STAGES{IDLE}};

   always_ff @(posedge clk) chain[0] <= d_async;

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) chain[i] <= chain[i-1];
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_countdown.sv
module rstseq_countdown
   import rstseq_pkg::*;
#(
   parameter int MAX = 64
) (
   input  logic clk,
   input  logic load,
   output logic busy
);
   localparam int CW = cnt_width(MAX);
   localparam logic [CW-1:0] FULL = CW'(MAX);

   if (MAX < 1) begin : g_bad_max
      $error("rstseq_countdown: MAX must be at least 1");
   end

   logic [CW-1:0] cnt = FULL;

   always_ff @(posedge clk) begin
      if (load)
         cnt <= FULL;
      else if (cnt != '0)
         cnt <= cnt - CW'(1);
   end

   assign busy = (cnt != '0);

   assert_reload_R5: assert property (@(posedge clk) load |=> cnt == FULL)
      else $error("countdown did not reload");
   assert_count_down_R3: assert property (@(posedge clk)
      (!load && cnt != '0) |=> cnt == $past(cnt) - CW'(1))
      else $error("countdown step wrong");
endmodule

// File: rtl/rstseq_outreg.sv
module rstseq_outreg (
   input  logic clk,
   input  logic req,
   output logic rst,
   output logic rst_n,
   output logic done
);
   logic rst_q  = 1'b1;
   logic rstn_q = 1'b0;
   logic done_q = 1'b0;

   always_ff @(posedge clk) begin
      rst_q  <= req;
      rstn_q <= ~req;
      done_q <= done_q | ~req;
   end

   assign rst   = rst_q;
   assign rst_n = rstn_q;
   assign done  = done_q;

   assert_complement_R6: assert property (@(posedge clk) rst_q != rstn_q)
      else $error("reset outputs not complementary");
   assert_done_sticky_R7: assert property (@(posedge clk) done_q |=> done_q)
      else $error("done flag cleared");
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
   parameter int POR_CYCLES     = 1024,
   parameter int STRETCH_CYCLES = 64,
   parameter int SYNC_STAGES    = 2
) (
   input  logic clk,
   input  logic btn_n_async,
   input  logic pll_lock_async,
   output logic sys_rst,
   output logic sys_rst_n,
   output logic seq_done
);
   if (POR_CYCLES < 1 || STRETCH_CYCLES < 1) begin : g_bad_counts
      $error("rstseq_top: counts must be at least 1");
   end

   logic btn_n_s, lock_s, cause, por_busy, str_busy, req;

   rstseq_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_btn (
      .clk(clk), .d_async(btn_n_async), .q(btn_n_s));
   rstseq_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sync_lock (
      .clk(clk), .d_async(pll_lock_async), .q(lock_s));

   assign cause = ~btn_n_s | ~lock_s;

   // power-up window: never reloaded, runs once from the initial value
   rstseq_countdown #(.MAX(POR_CYCLES)) u_por (
      .clk(clk), .load(1'b0), .busy(por_busy));
   // post-cause stretch: reloaded by every cycle a cause is present
   rstseq_countdown #(.MAX(STRETCH_CYCLES)) u_stretch (
      .clk(clk), .load(cause), .busy(str_busy));

   assign req = por_busy | str_busy | cause;

   rstseq_outreg u_out (
      .clk(clk), .req(req), .rst(sys_rst), .rst_n(sys_rst_n), .done(seq_done));

   assert_cause_holds_R2: assert property (@(posedge clk) cause |=> sys_rst)
      else $error("reset released while cause present");
   assert_por_holds_R1: assert property (@(posedge clk) por_busy |=> sys_rst)
      else $error("reset released during power-up window");
   assert_sync_release_R3: assert property (@(posedge clk)
      $fell(sys_rst) |-> !$past(str_busy))
      else $error("release during stretch");
endmodule

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb;
   localparam int POR = 20;
   localparam int STR = 5;

   logic clk = 1'b0;
   logic btn_n = 1'b1;
   logic lock = 1'b1;
   logic sys_rst, sys_rst_n, seq_done;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int exp_q[$];
   bit released_seen = 1'b0;
   logic prev_rst = 1'b1;
   bit finished = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rstseq_top #(.POR_CYCLES(POR), .STRETCH_CYCLES(STR), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .btn_n_async(btn_n), .pll_lock_async(lock),
      .sys_rst(sys_rst), .sys_rst_n(sys_rst_n), .seq_done(seq_done));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // driver helpers: drive at a falling edge; cyc then equals edges so far
   task automatic set_lock(input logic v, input bit expect_release);
      @(negedge clk);
      lock = v;
      if (expect_release) exp_q.push_back(cyc + STR + 3);
   endtask

   task automatic set_btn(input logic v, input bit expect_release);
      @(negedge clk);
      btn_n = v;
      if (expect_release) exp_q.push_back(cyc + STR + 3);
   endtask

   // monitor: scoreboard of release edges, plus per-cycle invariants
   initial begin
      forever begin
         @(negedge clk);
         check(sys_rst_n === ~sys_rst, "R6", sys_rst_n, !sys_rst);
         if (prev_rst === 1'b1 && sys_rst === 1'b0) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R3/R5 unexpected release", cyc, -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               check(cyc == e, "R1/R3/R4/R5 release edge", cyc, e);
            end
            released_seen = 1'b1;
         end
         check(seq_done === released_seen, "R7", seq_done, released_seen);
         prev_rst = sys_rst;
      end
   end

   initial begin
      #1;
      // reset state at time zero
      check(sys_rst === 1'b1, "R1 reset state", sys_rst, 1);
      check(sys_rst_n === 1'b0, "R6 reset state", sys_rst_n, 0);
      check(seq_done === 1'b0, "R7 reset state", seq_done, 0);
      exp_q.push_back(POR + 1);                // R1 power-up release
      while (cyc < POR + 6) @(negedge clk);
      check(sys_rst === 1'b0, "R1 released", sys_rst, 0);

      // R2/R3: lock loss and recovery
      set_lock(1'b0, 1'b0);
      repeat (3) @(negedge clk);
      check(sys_rst === 1'b1, "R2 assert latency", sys_rst, 1);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check(sys_rst === 1'b1, "R2 held while unlocked", sys_rst, 1);
      end
      set_lock(1'b1, 1'b1);
      repeat (STR + 8) @(negedge clk);
      check(sys_rst === 1'b0, "R3 released", sys_rst, 0);
      check(seq_done === 1'b1, "R7 sticky", seq_done, 1);

      // R4: button press, active low
      set_btn(1'b0, 1'b0);
      repeat (3) @(negedge clk);
      check(sys_rst === 1'b1, "R4 assert latency", sys_rst, 1);
      repeat (4) @(negedge clk);
      set_btn(1'b1, 1'b1);
      repeat (STR + 8) @(negedge clk);
      check(sys_rst === 1'b0, "R4 released", sys_rst, 0);

      // R5: new cause inside a running stretch reloads it
      set_lock(1'b0, 1'b0);
      repeat (5) @(negedge clk);
      set_lock(1'b1, 1'b0);
      repeat (4) @(negedge clk);
      check(sys_rst === 1'b1, "R5 inside stretch", sys_rst, 1);
      set_btn(1'b0, 1'b0);
      repeat (1) @(negedge clk);
      set_btn(1'b1, 1'b1);
      repeat (STR + 8) @(negedge clk);
      check(sys_rst === 1'b0, "R5 released", sys_rst, 0);

      // R4 again: one-cycle button pulse is still stretched
      set_btn(1'b0, 1'b0);
      set_btn(1'b1, 1'b1);
      repeat (STR + 8) @(negedge clk);
      check(exp_q.size() == 0, "R3/R4/R5 all releases seen", exp_q.size(), 0);
      summary();
   end

   initial begin
      #(20 * 5000);
      check(1'b0, "watchdog", cyc, 0);
      summary();
   end
endmodule